// File: doc/BRIEF.md
# Fault-Hardened Integer Register File

A 32-entry, 32-bit integer register file with one write port and two read ports, built to expose fault-injection attacks instead of silently returning bad data. Each address is decoded into a one-hot select vector before it touches storage. On the write side, the one-hot vector is the per-register write strobe. On the read side, each one-hot vector drives an AND-OR multiplexer. Every decoded vector is checked for a legal pattern.

The data words and their check bits live in two separate storage arrays. The data array is written with the write data. The check-bit array is written with a 7-bit SECDED Hamming code computed from that data at the write port. Both read ports recompute the code from the word they read and compare it with the stored check bits. The block does not correct a mismatch; it only reports it. Any detected fault sets one registered major alert, which stays set until reset. Writes take effect at the clock edge and reads are combinational.

Top module: `hardened_regfile`

## Requirements
- R1: After reset, every register reads 0 on both read ports and `majorAlert` is 0.
- R2: With `wrEn`=1 and `wrAddr`≠0, `wrData` is stored at the rising edge. It is visible on any read port addressing that register in the following cycle.
- R3: With `wrEn`=0, no register changes.
- R4: Register 0 always reads 0. Writes to it are ignored and do not raise the alert.
- R5: The two read ports work independently in the same cycle, including when both address the same register.
- R6: The decoded write-strobe vector has one bit per register and is legal only with zero or one bit set. Any vector with two or more bits set sets `majorAlert` at the next rising edge.
- R7: Each decoded read-select vector is legal only with exactly one bit set. A vector with no bits set, or with more than one, sets `majorAlert` at the next rising edge.
- R8: Each read port recomputes the check bits of the word it reads and compares them with the stored check bits. A mismatch from a one-bit or two-bit disagreement sets `majorAlert` at the next rising edge. The read data still returns the stored word unchanged.
- R9: Once set, `majorAlert` stays 1 until `rst_n` is asserted (active low), even after the fault goes away.
- R10: Legal reads and writes with any data pattern never set `majorAlert`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| wrEn | input | 1 | Write request |
| wrAddr | input | 5 | Write register index |
| wrData | input | 32 | Write data |
| rdAddrA | input | 5 | Read port A register index |
| rdDataA | output | 32 | Read port A data, combinational |
| rdAddrB | input | 5 | Read port B register index |
| rdDataB | output | 32 | Read port B data, combinational |
| majorAlert | output | 1 | Sticky registered fault alert |

## Verification
The storage is exercised with several data patterns: walking ones, alternating halves, all ones, and index-dependent values. These patterns separate address decoding faults from data path faults. The top and bottom indices, register 0, and both ports reading the same index are tried separately.

Faults are created by overriding the internal decoded vectors and the read-out words. Three cases are covered: a doubled write strobe, an empty or doubled read select, and one-bit and two-bit check mismatches. Each case shows that its own detector sets the alert. The alert is then shown to outlast the fault, and normal traffic is shown to leave the alert clear.

// File: rtl/hrf_pkg.sv
package hrf_pkg;
  localparam int unsigned RegCnt = 32;
  localparam int unsigned AddrW  = $clog2(RegCnt);
  localparam int unsigned DataW  = 32;
  localparam int unsigned HamW   = 6;
  localparam int unsigned EccW   = HamW + 1;

  // decoded strobes from control to datapath
  typedef struct packed {
    logic [RegCnt-1:0] wrOneHot;
    logic [RegCnt-1:0] selA;
    logic [RegCnt-1:0] selB;
  } hrf_strb_t;

  // detector outputs from datapath to control
  typedef struct packed {
    logic wrBad;
    logic selABad;
    logic selBBad;
    logic eccBadA;
    logic eccBadB;
  } hrf_flt_t;

  // Hamming code over codeword positions 1..; powers of two hold check bits,
  // plus one overall parity bit on top.
  function automatic logic [EccW-1:0] eccEncode(input logic [DataW-1:0] d);
    logic [EccW-1:0] c;
    int unsigned k;
    c = '0;
    k = 0;
    for (int unsigned p = 1; p < 64; p++) begin
      if (((p & (p - 1)) != 0) && (k < DataW)) begin
        for (int unsigned b = 0; b < HamW; b++) begin
          if (((p >> b) & 1) != 0) c[b] = c[b] ^ d[k];
        end
        k++;
      end
    end
    c[HamW] = (^d) ^ (^c[HamW-1:0]);
    return c;
  endfunction
endpackage

// File: rtl/hrf_store.sv
module hrf_store #(
  parameter int unsigned Depth = 32,
  parameter int unsigned Width = 32,
  parameter logic [Width-1:0] ResetVal = '0,
  parameter logic [Width-1:0] Slot0Val = '0
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [Depth-1:0]            wrVec,
  input  logic [Width-1:0]            wrWord,
  output logic [Depth-1:0][Width-1:0] words
);
  for (genvar i = 0; i < Depth; i++) begin : g_slot
    if (i == 0) begin : g_const
      assign words[i] = Slot0Val;
    end else begin : g_reg
      logic [Width-1:0] q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        q <= ResetVal;
        else if (wrVec[i]) q <= wrWord;
      end
      assign words[i] = q;
    end
  end
endmodule

// File: rtl/hrf_ctrl.sv
module hrf_ctrl
  import hrf_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wrEn,
  input  logic [AddrW-1:0] wrAddr,
  input  logic [AddrW-1:0] rdAddrA,
  input  logic [AddrW-1:0] rdAddrB,
  input  hrf_flt_t         flt,
  output hrf_strb_t        strb,
  output logic             majorAlert
);
  logic alertQ;
  logic anyFault;

  always_comb begin
    strb = '0;
    for (int unsigned i = 0; i < RegCnt; i++) begin
      // slot 0 is hardwired, so it never receives a strobe
      strb.wrOneHot[i] = wrEn && (i != 0) && (wrAddr == AddrW'(i));
      strb.selA[i]     = (rdAddrA == AddrW'(i));
      strb.selB[i]     = (rdAddrB == AddrW'(i));
    end
  end

  assign anyFault = flt.wrBad | flt.selABad | flt.selBBad | flt.eccBadA | flt.eccBadB;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) alertQ <= 1'b0;
    else        alertQ <= alertQ | anyFault;
  end

  assign majorAlert = alertQ;
endmodule

// File: rtl/hrf_datapath.sv
module hrf_datapath
  import hrf_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  hrf_strb_t        strb,
  input  logic [DataW-1:0] wrData,
  output logic [DataW-1:0] rdDataA,
  output logic [DataW-1:0] rdDataB,
  output hrf_flt_t         flt
);
  localparam logic [EccW-1:0] ZeroEcc = eccEncode('0);

  logic [RegCnt-1:0] wrVec, selA, selB;
  logic [EccW-1:0]   eccWr;
  logic [RegCnt-1:0][DataW-1:0] dataWords;
  logic [RegCnt-1:0][EccW-1:0]  eccWords;
  logic [DataW-1:0]  dataRdA, dataRdB;
  logic [EccW-1:0]   eccRdA, eccRdB;

  assign wrVec = strb.wrOneHot;
  assign selA  = strb.selA;
  assign selB  = strb.selB;
  assign eccWr = eccEncode(wrData);

  hrf_store #(.Depth(RegCnt), .Width(DataW), .ResetVal('0), .Slot0Val('0)) uData (
    .clk(clk), .rst_n(rst_n), .wrVec(wrVec), .wrWord(wrData), .words(dataWords)
  );

  hrf_store #(.Depth(RegCnt), .Width(EccW), .ResetVal(ZeroEcc), .Slot0Val(ZeroEcc)) uEcc (
    .clk(clk), .rst_n(rst_n), .wrVec(wrVec), .wrWord(eccWr), .words(eccWords)
  );

  // one-hot AND-OR read multiplexers
  always_comb begin
    dataRdA = '0; dataRdB = '0; eccRdA = '0; eccRdB = '0;
    for (int unsigned i = 0; i < RegCnt; i++) begin
      dataRdA = dataRdA | ({DataW{selA[i]}} & dataWords[i]);
      dataRdB = dataRdB | ({DataW{selB[i]}} & dataWords[i]);
      eccRdA  = eccRdA  | ({EccW{selA[i]}}  & eccWords[i]);
      eccRdB  = eccRdB  | ({EccW{selB[i]}}  & eccWords[i]);
    end
  end

  always_comb begin
    flt.wrBad   = |(wrVec & (wrVec - 1'b1));
    flt.selABad = (selA == '0) || (|(selA & (selA - 1'b1)));
    flt.selBBad = (selB == '0) || (|(selB & (selB - 1'b1)));
    flt.eccBadA = (eccEncode(dataRdA) != eccRdA);
    flt.eccBadB = (eccEncode(dataRdB) != eccRdB);
  end

  assign rdDataA = dataRdA;
  assign rdDataB = dataRdB;
endmodule

// File: rtl/hardened_regfile.sv
module hardened_regfile
  import hrf_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wrEn,
  input  logic [AddrW-1:0] wrAddr,
  input  logic [DataW-1:0] wrData,
  input  logic [AddrW-1:0] rdAddrA,
  output logic [DataW-1:0] rdDataA,
  input  logic [AddrW-1:0] rdAddrB,
  output logic [DataW-1:0] rdDataB,
  output logic             majorAlert
);
  hrf_strb_t strb;
  hrf_flt_t  flt;

  hrf_ctrl uCtrl (
    .clk(clk), .rst_n(rst_n), .wrEn(wrEn), .wrAddr(wrAddr),
    .rdAddrA(rdAddrA), .rdAddrB(rdAddrB), .flt(flt),
    .strb(strb), .majorAlert(majorAlert)
  );

  hrf_datapath uDp (
    .clk(clk), .rst_n(rst_n), .strb(strb), .wrData(wrData),
    .rdDataA(rdDataA), .rdDataB(rdDataB), .flt(flt)
  );
endmodule

// File: rtl/hrf_checker.sv
module hrf_checker
  import hrf_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             wrEn,
  input logic [AddrW-1:0] wrAddr,
  input logic [DataW-1:0] wrData,
  input logic [AddrW-1:0] rdAddrA,
  input logic [DataW-1:0] rdDataA,
  input logic [AddrW-1:0] rdAddrB,
  input logic [DataW-1:0] rdDataB,
  input logic             majorAlert
);
  p_alert_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    majorAlert |=> majorAlert);

  p_zero_reg_a_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (rdAddrA == '0) |-> (rdDataA == '0));

  p_zero_reg_b_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (rdAddrB == '0) |-> (rdDataB == '0));

  p_write_read_a_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wrEn && (wrAddr != '0) && !majorAlert) |=>
      ((rdAddrA != $past(wrAddr)) || (rdDataA == $past(wrData))));

  p_same_addr_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (rdAddrA == rdAddrB) |-> (rdDataA == rdDataB));
endmodule

bind hardened_regfile hrf_checker uChk (
  .clk(clk), .rst_n(rst_n), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
  .rdAddrA(rdAddrA), .rdDataA(rdDataA), .rdAddrB(rdAddrB), .rdDataB(rdDataB),
  .majorAlert(majorAlert)
);

// File: tb/tb_hardened_regfile.sv
`timescale 1ns/1ps
module tb_hardened_regfile;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wrEn = 1'b0;
  logic [4:0]  wrAddr = '0;
  logic [31:0] wrData = '0;
  logic [4:0]  rdAddrA = '0;
  logic [31:0] rdDataA;
  logic [4:0]  rdAddrB = '0;
  logic [31:0] rdDataB;
  logic        majorAlert;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;
  logic [31:0] model [32];

  always #2 clk = ~clk;

  hardened_regfile dut (
    .clk(clk), .rst_n(rst_n), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .rdAddrA(rdAddrA), .rdDataA(rdDataA), .rdAddrB(rdAddrB), .rdDataB(rdDataB),
    .majorAlert(majorAlert)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    wrEn = 1'b0; rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    for (int i = 0; i < 32; i++) model[i] = '0;
    @(negedge clk);
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    wrEn = 1'b1; wrAddr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
    if (a != 0) model[a] = d;
  endtask

  task automatic t_reset();
    for (int i = 0; i < 32; i++) begin
      rdAddrA = 5'(i); rdAddrB = 5'(31 - i);
      #1;
      check("R1 reset A", rdDataA, 32'h0);
      check("R1 reset B", rdDataB, 32'h0);
    end
    check("R1 alert", {31'b0, majorAlert}, 32'h0);
  endtask

  task automatic t_write_read();
    for (int i = 1; i < 32; i++) wr(5'(i), 32'h1 << (i - 1));
    wr(5'd31, 32'hFFFF_FFFF);
    wr(5'd16, 32'hA5A5_5A5A);
    wr(5'd1,  32'h0000_FFFF);
    for (int i = 0; i < 32; i++) begin
      rdAddrA = 5'(i); rdAddrB = 5'(i);
      #1;
      check("R2 read A", rdDataA, model[i]);
      check("R5 same addr B", rdDataB, model[i]);
    end
    for (int i = 1; i < 32; i++) wr(5'(i), {16'(i), 16'(~i)});
    for (int i = 0; i < 32; i++) begin
      rdAddrA = 5'(i); rdAddrB = 5'(31 - i);
      #1;
      check("R5 port A", rdDataA, model[i]);
      check("R5 port B", rdDataB, model[31 - i]);
    end
  endtask

  task automatic t_hold();
    wrEn = 1'b0; wrAddr = 5'd7; wrData = 32'hDEAD_BEEF;
    repeat (3) @(negedge clk);
    rdAddrA = 5'd7;
    #1;
    check("R3 no write", rdDataA, model[7]);
  endtask

  task automatic t_zero_reg();
    wr(5'd0, 32'h1234_5678);
    rdAddrA = 5'd0; rdAddrB = 5'd0;
    #1;
    check("R4 reg0 A", rdDataA, 32'h0);
    check("R4 reg0 B", rdDataB, 32'h0);
    check("R4 no alert", {31'b0, majorAlert}, 32'h0);
    check("R10 clean traffic", {31'b0, majorAlert}, 32'h0);
  endtask

  task automatic t_wr_fault();
    do_reset();
    rdAddrA = 5'd9; rdAddrB = 5'd10;
    force dut.uDp.wrVec = 32'h0000_0006;
    #1;
    check("R6 alert not yet", {31'b0, majorAlert}, 32'h0);
    @(negedge clk);
    release dut.uDp.wrVec;
    check("R6 double strobe alert", {31'b0, majorAlert}, 32'h1);
    repeat (3) @(negedge clk);
    check("R9 sticky", {31'b0, majorAlert}, 32'h1);
  endtask

  task automatic t_rd_fault();
    do_reset();
    rdAddrA = 5'd3; rdAddrB = 5'd4;
    force dut.uDp.selA = 32'h0;
    @(negedge clk);
    release dut.uDp.selA;
    check("R7 empty select", {31'b0, majorAlert}, 32'h1);
    do_reset();
    check("R9 cleared by reset", {31'b0, majorAlert}, 32'h0);
    rdAddrA = 5'd3; rdAddrB = 5'd4;
    force dut.uDp.selB = 32'h0000_0018;
    @(negedge clk);
    release dut.uDp.selB;
    check("R7 double select", {31'b0, majorAlert}, 32'h1);
  endtask

  task automatic t_ecc_fault();
    do_reset();
    rdAddrA = 5'd5; rdAddrB = 5'd6;
    force dut.uDp.eccRdA = 7'h01;
    @(negedge clk);
    release dut.uDp.eccRdA;
    check("R8 one-bit check mismatch", {31'b0, majorAlert}, 32'h1);
    do_reset();
    rdAddrA = 5'd5; rdAddrB = 5'd6;
    force dut.uDp.eccRdB = 7'h03;
    @(negedge clk);
    release dut.uDp.eccRdB;
    check("R8 two-bit check mismatch", {31'b0, majorAlert}, 32'h1);
    do_reset();
    rdAddrA = 5'd5; rdAddrB = 5'd6;
    force dut.uDp.dataRdA = 32'h0000_0001;
    #1;
    check("R8 data not corrected", rdDataA, 32'h0000_0001);
    @(negedge clk);
    release dut.uDp.dataRdA;
    check("R8 data flip alert", {31'b0, majorAlert}, 32'h1);
    repeat (4) @(negedge clk);
    check("R9 sticky after fault gone", {31'b0, majorAlert}, 32'h1);
  endtask

  initial begin
    for (int i = 0; i < 32; i++) model[i] = '0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_write_read();
    t_hold();
    t_zero_reg();
    t_wr_fault();
    t_rd_fault();
    t_ecc_fault();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      done = 1'b1;
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule